// File: doc/BRIEF.md
# Display RAM Address Counter With Line Mapping

This block holds the 7-bit pointer into a character display's data RAM. A set-address instruction loads it directly. Every later RAM read or write steps it by one, up or down. How the RAM is split among display lines depends on the line mode, so the legal addresses form one, two or four separate windows. The counter never walks through the unused gaps. At the end of a window it jumps to the next window. Past the last window it returns to 00h, and a downward step mirrors this.

The current address is always visible on the output, for example for a status read. A combinational flag says whether that address lies inside a legal window of the present line mode. An address loaded outside every window is kept as it is, with the flag low. The next step moves it into the nearest window in the step direction.

Top module: `dac_addr_counter`

## Requirements
- R1: After the asynchronous active-low reset, `addr` is 00h and `addr_valid` is 1.
- R2: When `load_en` is 1 at a rising clock edge, `addr` takes `load_addr` after that edge, whatever `step_en` is.
- R3: When both `load_en` and `step_en` are 0 at an edge, `addr` keeps its value.
- R4: With `line_mode` = 00 (one line), the window is 00h..4Fh. An upward step from 4Fh gives 00h and a downward step from 00h gives 4Fh.
- R5: With `line_mode` = 01 (two lines), the windows are 00h..27h and 40h..67h. Upward steps go 27h to 40h and 67h to 00h. Downward steps go 40h to 27h and 00h to 67h.
- R6: With `line_mode` = 10 or 11 (four lines), the windows are 00h..13h, 20h..33h, 40h..53h and 60h..73h. Upward steps go 13h to 20h, 33h to 40h, 53h to 60h and 73h to 00h. Downward steps mirror this, and 00h goes to 73h.
- R7: Inside a window and away from its ends, a step with `step_up` = 1 adds one and a step with `step_up` = 0 subtracts one.
- R8: `addr_valid` is 0 exactly when `addr` is outside every window of the current mode. A step from such an address goes to the nearest window in the step direction. Upward, that is the first window start above the address, or 00h if there is none. Downward, it is the last window end below the address, or the last window's end if there is none.
- R9: `addr_valid` follows a change of `line_mode` in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_mode | input | 2 | 00 one line, 01 two lines, 10/11 four lines |
| load_en | input | 1 | Load `load_addr` at the next edge |
| load_addr | input | 7 | Address from the set-address instruction |
| step_en | input | 1 | Step once after a RAM access |
| step_up | input | 1 | 1 = increment, 0 = decrement |
| addr | output | 7 | Current RAM address |
| addr_valid | output | 1 | Current address lies inside a legal window |

## Verification
The bench builds the block with its default parameters: a 7-bit address and windows of 80, 40 and 20 entries. This puts every one of the 128 codes within reach in all four mode codes. An exhaustive sweep loads each code and checks the flag and one step in each direction against a search-based model. Directed tasks cover the window seams, load priority, hold and live mode switching.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [1:0] {
    LM_ONE      = 2'b00,
    LM_TWO      = 2'b01,
    LM_FOUR     = 2'b10,
    LM_FOUR_ALT = 2'b11
  } line_mode_e;
endpackage

// File: rtl/dac_window.sv
// Maps the line mode to the window geometry: stride as a shift amount, and length.
module dac_window #(
  parameter int AW   = 7,
  parameter int LEN1 = 80,
  parameter int LEN2 = 40,
  parameter int LEN4 = 20,
  localparam int SHW = $clog2(AW + 1)
) (
  input  logic [1:0]   mode,
  output logic [SHW-1:0] win_sh,
  output logic [AW:0]  win_len
);
  import dac_pkg::*;

  always_comb begin
    unique case (line_mode_e'(mode))
      LM_ONE: begin
        win_sh  = SHW'(AW);
        win_len = (AW+1)'(LEN1);
      end
      LM_TWO: begin
        win_sh  = SHW'(AW - 1);
        win_len = (AW+1)'(LEN2);
      end
      default: begin
        win_sh  = SHW'(AW - 2);
        win_len = (AW+1)'(LEN4);
      end
    endcase
  end
endmodule

// File: rtl/dac_step.sv
// Next-address arithmetic over discontinuous windows.
module dac_step #(
  parameter int AW = 7,
  localparam int SHW = $clog2(AW + 1)
) (
  input  logic [AW-1:0]  cur,
  input  logic           up,
  input  logic [SHW-1:0] win_sh,
  input  logic [AW:0]    win_len,
  output logic [AW-1:0]  nxt,
  output logic           in_win,
  output logic           jump
);
  localparam logic [AW:0] SPAN = (AW+1)'(1) << AW;

  function automatic logic [AW:0] f_stride(input logic [SHW-1:0] sh);
    return (AW+1)'(1) << sh;
  endfunction

  function automatic logic [AW:0] f_inc(input logic [AW:0] a, input logic [AW:0] st,
                                        input logic [AW:0] len);
    logic [AW:0] off, base;
    off  = a & (st - 1'b1);
    base = a - off;
    if (off + 1'b1 < len)     return a + 1'b1;
    else if (base == SPAN - st) return '0;
    else                      return base + st;
  endfunction

  function automatic logic [AW:0] f_dec(input logic [AW:0] a, input logic [AW:0] st,
                                        input logic [AW:0] len);
    logic [AW:0] off, base;
    off  = a & (st - 1'b1);
    base = a - off;
    if (off >= len)           return base + len - 1'b1;
    else if (off != '0)       return a - 1'b1;
    else if (base == '0)      return SPAN - st + len - 1'b1;
    else                      return base - st + len - 1'b1;
  endfunction

  logic [AW:0] a_ext, stride, off, raw;

  always_comb begin
    a_ext  = {1'b0, cur};
    stride = f_stride(win_sh);
    off    = a_ext & (stride - 1'b1);
    in_win = off < win_len;
    raw    = up ? f_inc(a_ext, stride, win_len) : f_dec(a_ext, stride, win_len);
    nxt    = raw[AW-1:0];
    jump   = up ? (off + 1'b1 >= win_len) : (off == '0 || off >= win_len);
  end
endmodule

// File: rtl/dac_addr_counter.sv
module dac_addr_counter #(
  parameter int AW   = 7,
  parameter int LEN1 = 80,
  parameter int LEN2 = 40,
  parameter int LEN4 = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    line_mode,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic          step_en,
  input  logic          step_up,
  output logic [AW-1:0] addr,
  output logic          addr_valid
);
  localparam int SHW = $clog2(AW + 1);

  logic [SHW-1:0] win_sh;
  logic [AW:0]    win_len;
  logic [AW-1:0]  step_nxt;
  logic           step_jump;
  logic           step_fire;

  dac_window #(.AW(AW), .LEN1(LEN1), .LEN2(LEN2), .LEN4(LEN4)) u_win (
    .mode    (line_mode),
    .win_sh  (win_sh),
    .win_len (win_len)
  );

  dac_step #(.AW(AW)) u_step (
    .cur     (addr),
    .up      (step_up),
    .win_sh  (win_sh),
    .win_len (win_len),
    .nxt     (step_nxt),
    .in_win  (addr_valid),
    .jump    (step_jump)
  );

  assign step_fire = step_en && !load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load_en) addr <= load_addr;
    else if (step_en) addr <= step_nxt;
  end

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> addr == $past(load_addr)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> addr == $past(addr)); // R3
  AST_STEP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (line_mode != $past(line_mode)) || addr_valid); // R8
  AST_PLAIN_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && step_up && !step_jump) |=> addr == $past(addr) + 1'b1); // R7
  AST_PLAIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !step_up && !step_jump) |=> addr == $past(addr) - 1'b1); // R7
endmodule

// File: tb/dac_addr_counter_test.sv
module dac_addr_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_mode = 2'b00;
  logic       load_en = 1'b0;
  logic [6:0] load_addr = '0;
  logic       step_en = 1'b0;
  logic       step_up = 1'b1;
  logic [6:0] addr;
  logic       addr_valid;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  dac_addr_counter uut (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .load_en(load_en),
    .load_addr(load_addr), .step_en(step_en), .step_up(step_up),
    .addr(addr), .addr_valid(addr_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Model: explicit ranges per mode.
  function automatic bit m_valid(input logic [1:0] m, input int a);
    case (m)
      2'b00:   return a <= 8'h4F;
      2'b01:   return (a <= 8'h27) || (a >= 8'h40 && a <= 8'h67);
      default: return (a <= 8'h13) || (a >= 8'h20 && a <= 8'h33) ||
                      (a >= 8'h40 && a <= 8'h53) || (a >= 8'h60 && a <= 8'h73);
    endcase
  endfunction

  // Model: search for the nearest legal code in the step direction, cyclically.
  function automatic int m_next(input logic [1:0] m, input int a, input bit up);
    for (int k = 1; k <= 128; k++) begin
      int c;
      c = up ? (a + k) % 128 : (a - k + 128) % 128;
      if (m_valid(m, c)) return c;
    end
    return a;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int a);
    @(negedge clk);
    load_en = 1'b1; load_addr = 7'(a);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_step(input bit up);
    @(negedge clk);
    step_en = 1'b1; step_up = up;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic seam(input string req, input logic [1:0] m, input int from,
                      input bit up, input int exp);
    line_mode = m;
    do_load(from);
    do_step(up);
    check(req, addr, exp);
    check(req, addr_valid, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R1", addr, 0);
    check("R1", addr_valid, 1);
    @(negedge clk); rst_n = 1'b1;
    check("R1", addr, 0);
  endtask

  task automatic t_load_priority();
    line_mode = 2'b00;
    @(negedge clk);
    load_en = 1'b1; step_en = 1'b1; step_up = 1'b1; load_addr = 7'h22;
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
    check("R2", addr, 8'h22);
  endtask

  task automatic t_hold();
    do_load(8'h11);
    repeat (3) @(negedge clk);
    check("R3", addr, 8'h11);
  endtask

  task automatic t_mode1();
    seam("R4", 2'b00, 8'h4F, 1'b1, 8'h00);
    seam("R4", 2'b00, 8'h00, 1'b0, 8'h4F);
    seam("R7", 2'b00, 8'h30, 1'b1, 8'h31);
    seam("R7", 2'b00, 8'h30, 1'b0, 8'h2F);
  endtask

  task automatic t_mode2();
    seam("R5", 2'b01, 8'h27, 1'b1, 8'h40);
    seam("R5", 2'b01, 8'h67, 1'b1, 8'h00);
    seam("R5", 2'b01, 8'h40, 1'b0, 8'h27);
    seam("R5", 2'b01, 8'h00, 1'b0, 8'h67);
  endtask

  task automatic t_mode4();
    seam("R6", 2'b10, 8'h13, 1'b1, 8'h20);
    seam("R6", 2'b10, 8'h33, 1'b1, 8'h40);
    seam("R6", 2'b10, 8'h53, 1'b1, 8'h60);
    seam("R6", 2'b10, 8'h73, 1'b1, 8'h00);
    seam("R6", 2'b10, 8'h00, 1'b0, 8'h73);
    seam("R6", 2'b11, 8'h60, 1'b0, 8'h53);
    seam("R6", 2'b11, 8'h13, 1'b1, 8'h20);
  endtask

  task automatic t_outside();
    line_mode = 2'b01;
    do_load(8'h30);
    check("R8", addr, 8'h30);
    check("R8", addr_valid, 0);
    do_step(1'b1);
    check("R8", addr, 8'h40);
    seam("R8", 2'b01, 8'h30, 1'b0, 8'h27);
    seam("R8", 2'b01, 8'h70, 1'b1, 8'h00);
    seam("R8", 2'b10, 8'h78, 1'b0, 8'h73);
    seam("R8", 2'b00, 8'h60, 1'b0, 8'h4F);
  endtask

  task automatic t_mode_switch();
    line_mode = 2'b00;
    do_load(8'h30);
    check("R9", addr_valid, 1);
    line_mode = 2'b01; #1;
    check("R9", addr_valid, 0);
    line_mode = 2'b10; #1;
    check("R9", addr_valid, 1);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 128; a++) begin
        line_mode = 2'(m);
        do_load(a);
        check("R8", addr_valid, int'(m_valid(2'(m), a)));
        do_step(1'b1);
        check("R7", addr, m_next(2'(m), a, 1'b1));
        do_load(a);
        do_step(1'b0);
        check("R7", addr, m_next(2'(m), a, 1'b0));
      end
    end
  endtask

  initial begin
    t_reset();
    t_load_priority();
    t_hold();
    t_mode1();
    t_mode2();
    t_mode4();
    t_outside();
    t_mode_switch();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule